// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block is a fully associative translation buffer for virtual-to-physical address mapping. Each entry covers a pair of adjacent virtual pages, an even page and an odd page. Each half has its own physical frame, valid bit and dirty bit. A per-entry page mask sets how large the pages of that entry are. The smallest pair is two 4 KB pages. An entry applies to one address-space ID (ASID), or to every ASID when its global bit is set.

The block has four uses:
- **Lookup.** The lookup port is combinational. It takes a virtual address, an ASID and a read/write flag, and returns a translation or a fault code.
- **Indexed write.** Software loads an entry at a chosen index from four staging registers: entry-high, entry-low-even, entry-low-odd and page-mask. The write takes effect at the next clock edge.
- **Probe.** A probe is a small state machine that scans the entries one per cycle, lowest index first. It uses entry-high as the search key and writes the result into the index register.
- **Read-back.** The fields of the entry selected by the index register are always visible in register form.

The probe state machine has three states:
- PS_IDLE goes to PS_SCAN when `probe_go` is high. The scan counter is cleared on this transition.
- PS_SCAN goes to PS_DONE when the entry under the counter matches, or when the last entry has been checked. Otherwise it stays in PS_SCAN and increments the counter.
- PS_DONE always returns to PS_IDLE.

Top module: `tlbp_top`

## Requirements
- R1: An entry matches when its global bit is set or its stored 8-bit ASID equals the presented ASID, and the address and stored page number agree above the effective mask. When several entries match, the lowest index is used.
- R2: The effective mask is the entry's page mask ORed with 0x1FFF. Bits under the effective mask, in either the stored page number or the presented address, never affect a match.
- R3: The half is selected by the address bit at the top of the effective mask, that is, the bit set in mask but clear in mask>>1. That bit is 0 for the even half and 1 for the odd half.
- R4: A match whose selected half has its valid bit clear returns fault code 2 (invalid) and `lk_hit` low.
- R5: A write lookup (`lk_write`=1) on a half whose dirty bit is clear returns fault code 3 (modified). A read lookup ignores the dirty bit.
- R6: On success, `lk_fault` is 0, `lk_hit` is high, and `lk_pa` equals the half's frame number (entry-low bits [31:12]) followed by twelve zero bits, ORed with the address bits under mask>>1. `lk_pa` is 0 whenever `lk_hit` is low.
- R7: An indexed write stores the following, and read-back returns the entry at `index_q[3:0]` in the same register formats:
  - the page number, taken as entry-high with bits [12:0] cleared;
  - the ASID, taken from entry-high [7:0];
  - the page mask, copied unchanged;
  - the global bit, which is the AND of bit 0 of both entry-low registers;
  - for each half, the valid bit from entry-low bit 1, the dirty bit from entry-low bit 2, and the frame from entry-low bits [31:12].

  Read-back returns entry-low bits [11:3] as zero, and bit 0 of both halves as the global bit.
- R8: A probe started by `probe_go` in PS_IDLE finds the first matching entry in ascending order. It writes that index into `index_q[3:0]` and clears `index_q[31]`. `probe_done` is high for exactly one cycle, and `index_q` changes only in that cycle.
- R9: A probe that finds no match sets `index_q[31]` and leaves `index_q[3:0]` unchanged.
- R10: A lookup with no matching entry returns fault code 1 (miss).
- R11: After reset, `index_q` is 0, the probe is idle, and every entry is zero. A lookup with any non-zero ASID therefore misses.
- R12: `probe_busy` is high in PS_SCAN, and `probe_go` has no effect outside PS_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space ID |
| lk_write | input | 1 | Lookup is a store access |
| lk_hit | output | 1 | Translation succeeded |
| lk_pa | output | 32 | Physical address |
| lk_fault | output | 2 | 0 ok, 1 miss, 2 invalid, 3 modified |
| reg_hi | input | 32 | Entry-high staging register |
| reg_lo0 | input | 32 | Even-half entry-low register |
| reg_lo1 | input | 32 | Odd-half entry-low register |
| reg_pmask | input | 32 | Page-mask register |
| wr_en | input | 1 | Indexed write strobe |
| wr_index | input | 4 | Entry to write |
| probe_go | input | 1 | Start a probe |
| probe_busy | output | 1 | Probe scanning |
| probe_done | output | 1 | Probe result valid this cycle |
| index_q | output | 32 | Index register; bit 31 means the probe failed |
| rd_hi | output | 32 | Read-back entry-high |
| rd_lo0 | output | 32 | Read-back even entry-low |
| rd_lo1 | output | 32 | Read-back odd entry-low |
| rd_pmask | output | 32 | Read-back page mask |

## Verification
Directed lookups cover four contrasts:
- an even-half address against an odd-half address, which separates the two frames;
- a read against a write to a clean half, which separates ok from modified;
- a matching ASID, a foreign ASID and a global entry;
- a large page whose stored page number carries stale bits under the mask, which shows the mask is applied on both sides of the compare.

Directed probes cover duplicate entries, which expose the scan order, and a key with no match, which shows the index field is kept. Random writes, lookups and probes are drawn from a small address window with three page sizes and three ASIDs. The window is kept small so that hits, overlaps and misses all occur often, and every response is compared against a bench model of the match rules.

// File: rtl/tlbp_pkg.sv
`timescale 1ns/1ps
package tlbp_pkg;
    // lookup result codes
    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_MISS     = 2'd1,
        FLT_INVALID  = 2'd2,
        FLT_MODIFIED = 2'd3
    } fault_e;

    // probe scanner states
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_SCAN = 2'd1,
        PS_DONE = 2'd2
    } pstate_e;

    // smallest pair spans 2 x 4 KB, so the low 13 bits always sit under the mask
    localparam int PAIR_FLOOR_BITS = 13;
    localparam int FRAME_LSB       = 12;
endpackage

// File: rtl/tlbp_cmp.sv
`timescale 1ns/1ps
module tlbp_cmp #(
    parameter int VA_W   = 32,
    parameter int ASID_W = 8
) (
    input  logic [VA_W-1:0]   addr,
    input  logic [ASID_W-1:0] asid,
    input  logic [VA_W-1:0]   e_vpn,
    input  logic [VA_W-1:0]   e_mask,
    input  logic [ASID_W-1:0] e_asid,
    input  logic              e_g,
    output logic              hit,
    output logic              odd,
    output logic [VA_W-1:0]   eff_mask
);
    import tlbp_pkg::*;

    localparam logic [VA_W-1:0] FLOOR = VA_W'((64'd1 << PAIR_FLOOR_BITS) - 64'd1);

    logic owner_ok;
    logic page_ok;

    always_comb begin
        eff_mask = e_mask | FLOOR;
        owner_ok = e_g || (e_asid == asid);
        // both sides masked: stale low bits in the stored number are harmless
        page_ok  = ((addr & ~eff_mask) == (e_vpn & ~eff_mask));
        hit      = owner_ok && page_ok;
        odd      = |(addr & eff_mask & ~(eff_mask >> 1));
    end
endmodule

// File: rtl/tlbp_store.sv
`timescale 1ns/1ps
module tlbp_store #(
    parameter int N      = 16,
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int ASID_W = 8,
    parameter int IDX_W  = 4,
    parameter int FW     = 20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [VA_W-1:0]             hi,
    input  logic [PA_W-1:0]             lo0,
    input  logic [PA_W-1:0]             lo1,
    input  logic [VA_W-1:0]             pmask,
    output logic [N-1:0][VA_W-1:0]      e_vpn,
    output logic [N-1:0][VA_W-1:0]      e_mask,
    output logic [N-1:0][ASID_W-1:0]    e_asid,
    output logic [N-1:0]                e_g,
    output logic [N-1:0]                e_v0,
    output logic [N-1:0]                e_v1,
    output logic [N-1:0]                e_d0,
    output logic [N-1:0]                e_d1,
    output logic [N-1:0][FW-1:0]        e_pf0,
    output logic [N-1:0][FW-1:0]        e_pf1
);
    import tlbp_pkg::*;

    localparam logic [VA_W-1:0] FLOOR = VA_W'((64'd1 << PAIR_FLOOR_BITS) - 64'd1);

    logic unused_lo_bits;
    assign unused_lo_bits = ^{lo0[FRAME_LSB-1:3], lo1[FRAME_LSB-1:3]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_vpn  <= '0;
            e_mask <= '0;
            e_asid <= '0;
            e_g    <= '0;
            e_v0   <= '0;
            e_v1   <= '0;
            e_d0   <= '0;
            e_d1   <= '0;
            e_pf0  <= '0;
            e_pf1  <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < N; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    e_vpn[i]  <= hi & ~FLOOR;
                    e_asid[i] <= hi[ASID_W-1:0];
                    e_mask[i] <= pmask;
                    e_g[i]    <= lo0[0] & lo1[0];
                    e_v0[i]   <= lo0[1];
                    e_d0[i]   <= lo0[2];
                    e_v1[i]   <= lo1[1];
                    e_d1[i]   <= lo1[2];
                    e_pf0[i]  <= lo0[PA_W-1:FRAME_LSB];
                    e_pf1[i]  <= lo1[PA_W-1:FRAME_LSB];
                end
            end
        end
    end
endmodule

// File: rtl/tlbp_lookup.sv
`timescale 1ns/1ps
module tlbp_lookup #(
    parameter int N      = 16,
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int ASID_W = 8,
    parameter int FW     = 20
) (
    input  logic [VA_W-1:0]             va,
    input  logic [ASID_W-1:0]           asid,
    input  logic                        is_wr,
    input  logic [N-1:0][VA_W-1:0]      e_vpn,
    input  logic [N-1:0][VA_W-1:0]      e_mask,
    input  logic [N-1:0][ASID_W-1:0]    e_asid,
    input  logic [N-1:0]                e_g,
    input  logic [N-1:0]                e_v0,
    input  logic [N-1:0]                e_v1,
    input  logic [N-1:0]                e_d0,
    input  logic [N-1:0]                e_d1,
    input  logic [N-1:0][FW-1:0]        e_pf0,
    input  logic [N-1:0][FW-1:0]        e_pf1,
    output logic                        hit,
    output tlbp_pkg::fault_e            fault,
    output logic [PA_W-1:0]             pa
);
    import tlbp_pkg::*;

    logic [N-1:0]           m_hit;
    logic [N-1:0]           m_odd;
    logic [N-1:0][VA_W-1:0] m_mask;

    for (genvar gi = 0; gi < N; gi++) begin : g_cmp
        tlbp_cmp #(.VA_W(VA_W), .ASID_W(ASID_W)) u_cmp (
            .addr     (va),
            .asid     (asid),
            .e_vpn    (e_vpn[gi]),
            .e_mask   (e_mask[gi]),
            .e_asid   (e_asid[gi]),
            .e_g      (e_g[gi]),
            .hit      (m_hit[gi]),
            .odd      (m_odd[gi]),
            .eff_mask (m_mask[gi])
        );
    end

    always_comb begin
        logic            found;
        logic            sel_v;
        logic            sel_d;
        logic [FW-1:0]   sel_pf;
        logic [VA_W-1:0] offs;
        found  = 1'b0;
        sel_v  = 1'b0;
        sel_d  = 1'b0;
        sel_pf = '0;
        offs   = '0;
        // lowest index wins
        for (int i = 0; i < N; i++) begin
            if (m_hit[i] && !found) begin
                found  = 1'b1;
                sel_v  = m_odd[i] ? e_v1[i]  : e_v0[i];
                sel_d  = m_odd[i] ? e_d1[i]  : e_d0[i];
                sel_pf = m_odd[i] ? e_pf1[i] : e_pf0[i];
                offs   = va & (m_mask[i] >> 1);
            end
        end
        if (!found)
            fault = FLT_MISS;
        else if (!sel_v)
            fault = FLT_INVALID;
        else if (is_wr && !sel_d)
            fault = FLT_MODIFIED;
        else
            fault = FLT_NONE;
        hit = (fault == FLT_NONE);
        pa  = hit ? ({sel_pf, {FRAME_LSB{1'b0}}} | PA_W'(offs)) : '0;
    end
endmodule

// File: rtl/tlbp_probe.sv
`timescale 1ns/1ps
module tlbp_probe #(
    parameter int N      = 16,
    parameter int VA_W   = 32,
    parameter int ASID_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        go,
    input  logic [VA_W-1:0]             key,
    input  logic [N-1:0][VA_W-1:0]      e_vpn,
    input  logic [N-1:0][VA_W-1:0]      e_mask,
    input  logic [N-1:0][ASID_W-1:0]    e_asid,
    input  logic [N-1:0]                e_g,
    output logic                        busy,
    output logic                        done,
    output logic [31:0]                 index_q
);
    import tlbp_pkg::*;

    pstate_e          st_q;
    pstate_e          st_nx;
    logic [IDX_W-1:0] cnt_q;
    logic             cur_hit;
    logic             cur_odd;
    logic [VA_W-1:0]  cur_mask;
    logic             last;

    tlbp_cmp #(.VA_W(VA_W), .ASID_W(ASID_W)) u_cmp (
        .addr     (key),
        .asid     (key[ASID_W-1:0]),
        .e_vpn    (e_vpn[cnt_q]),
        .e_mask   (e_mask[cnt_q]),
        .e_asid   (e_asid[cnt_q]),
        .e_g      (e_g[cnt_q]),
        .hit      (cur_hit),
        .odd      (cur_odd),
        .eff_mask (cur_mask)
    );

    logic unused_cmp;
    assign unused_cmp = cur_odd ^ (^cur_mask);

    assign last = (cnt_q == IDX_W'(N - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PS_IDLE;
        else        st_q <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            PS_IDLE: if (go) st_nx = PS_SCAN;
            PS_SCAN: if (cur_hit || last) st_nx = PS_DONE;
            PS_DONE: st_nx = PS_IDLE;
            default: st_nx = PS_IDLE;
        endcase
    end

    // scan counter and index register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            index_q <= '0;
        end else begin
            unique case (st_q)
                PS_IDLE: if (go) cnt_q <= '0;
                PS_SCAN: begin
                    if (cur_hit) begin
                        index_q <= 32'(cnt_q);
                    end else if (last) begin
                        index_q[31] <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PS_DONE: cnt_q <= cnt_q;
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy = (st_q == PS_SCAN);
        done = (st_q == PS_DONE);
    end
endmodule

// File: rtl/tlbp_top.sv
`timescale 1ns/1ps
module tlbp_top #(
    parameter int N      = 16,
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int ASID_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [VA_W-1:0]       lk_va,
    input  logic [ASID_W-1:0]     lk_asid,
    input  logic                  lk_write,
    output logic                  lk_hit,
    output logic [PA_W-1:0]       lk_pa,
    output logic [1:0]            lk_fault,
    input  logic [VA_W-1:0]       reg_hi,
    input  logic [PA_W-1:0]       reg_lo0,
    input  logic [PA_W-1:0]       reg_lo1,
    input  logic [VA_W-1:0]       reg_pmask,
    input  logic                  wr_en,
    input  logic [$clog2(N)-1:0]  wr_index,
    input  logic                  probe_go,
    output logic                  probe_busy,
    output logic                  probe_done,
    output logic [31:0]           index_q,
    output logic [VA_W-1:0]       rd_hi,
    output logic [PA_W-1:0]       rd_lo0,
    output logic [PA_W-1:0]       rd_lo1,
    output logic [VA_W-1:0]       rd_pmask
);
    import tlbp_pkg::*;

    localparam int IDX_W = $clog2(N);
    localparam int FW    = PA_W - FRAME_LSB;

    logic [N-1:0][VA_W-1:0]   e_vpn;
    logic [N-1:0][VA_W-1:0]   e_mask;
    logic [N-1:0][ASID_W-1:0] e_asid;
    logic [N-1:0]             e_g;
    logic [N-1:0]             e_v0;
    logic [N-1:0]             e_v1;
    logic [N-1:0]             e_d0;
    logic [N-1:0]             e_d1;
    logic [N-1:0][FW-1:0]     e_pf0;
    logic [N-1:0][FW-1:0]     e_pf1;
    fault_e                   lk_code;
    logic [IDX_W-1:0]         rb_sel;

    tlbp_store #(.N(N), .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W),
                 .IDX_W(IDX_W), .FW(FW)) u_store (
        .clk (clk), .rst_n (rst_n),
        .wr_en (wr_en), .wr_idx (wr_index),
        .hi (reg_hi), .lo0 (reg_lo0), .lo1 (reg_lo1), .pmask (reg_pmask),
        .e_vpn (e_vpn), .e_mask (e_mask), .e_asid (e_asid), .e_g (e_g),
        .e_v0 (e_v0), .e_v1 (e_v1), .e_d0 (e_d0), .e_d1 (e_d1),
        .e_pf0 (e_pf0), .e_pf1 (e_pf1)
    );

    tlbp_lookup #(.N(N), .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W),
                  .FW(FW)) u_lookup (
        .va (lk_va), .asid (lk_asid), .is_wr (lk_write),
        .e_vpn (e_vpn), .e_mask (e_mask), .e_asid (e_asid), .e_g (e_g),
        .e_v0 (e_v0), .e_v1 (e_v1), .e_d0 (e_d0), .e_d1 (e_d1),
        .e_pf0 (e_pf0), .e_pf1 (e_pf1),
        .hit (lk_hit), .fault (lk_code), .pa (lk_pa)
    );

    tlbp_probe #(.N(N), .VA_W(VA_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_probe (
        .clk (clk), .rst_n (rst_n),
        .go (probe_go), .key (reg_hi),
        .e_vpn (e_vpn), .e_mask (e_mask), .e_asid (e_asid), .e_g (e_g),
        .busy (probe_busy), .done (probe_done), .index_q (index_q)
    );

    assign lk_fault = lk_code;
    assign rb_sel   = index_q[IDX_W-1:0];

    // read-back in staging-register format
    always_comb begin
        rd_hi    = e_vpn[rb_sel] | VA_W'(e_asid[rb_sel]);
        rd_lo0   = {e_pf0[rb_sel], {(FRAME_LSB-3){1'b0}},
                    e_d0[rb_sel], e_v0[rb_sel], e_g[rb_sel]};
        rd_lo1   = {e_pf1[rb_sel], {(FRAME_LSB-3){1'b0}},
                    e_d1[rb_sel], e_v1[rb_sel], e_g[rb_sel]};
        rd_pmask = e_mask[rb_sel];
    end
endmodule

// File: rtl/tlbp_chk.sv
`timescale 1ns/1ps
module tlbp_chk #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int IDX_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [VA_W-1:0] lk_va,
    input logic            lk_hit,
    input logic [PA_W-1:0] lk_pa,
    input logic            probe_go,
    input logic            probe_busy,
    input logic            probe_done,
    input logic [31:0]     index_q
);
    // page offset always passes through untranslated
    assert_pa_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_pa[11:0] == lk_va[11:0]));

    // a go seen while idle starts the scan
    assert_go_starts_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_go && !probe_busy && !probe_done) |=> probe_busy);

    // completion lasts one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        probe_done |=> !probe_done);

    // index register moves only with a completion
    assert_index_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(index_q) |-> probe_done);

    // failed probe keeps the index field
    assert_fail_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_done && index_q[31]) |-> (index_q[IDX_W-1:0] == $past(index_q[IDX_W-1:0])));
endmodule

bind tlbp_top tlbp_chk #(.VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_va      (lk_va),
    .lk_hit     (lk_hit),
    .lk_pa      (lk_pa),
    .probe_go   (probe_go),
    .probe_busy (probe_busy),
    .probe_done (probe_done),
    .index_q    (index_q)
);

// File: tb/sim_tlbp_top.sv
`timescale 1ns/1ps
module sim_tlbp_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_write = 1'b0;
    logic        lk_hit;
    logic [31:0] lk_pa;
    logic [1:0]  lk_fault;
    logic [31:0] reg_hi = '0, reg_lo0 = '0, reg_lo1 = '0, reg_pmask = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_index = '0;
    logic        probe_go = 1'b0;
    logic        probe_busy, probe_done;
    logic [31:0] index_q, rd_hi, rd_lo0, rd_lo1, rd_pmask;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    // bench model
    logic [31:0] m_vpn[16], m_mask[16], m_pf0[16], m_pf1[16];
    logic [7:0]  m_asid[16];
    bit          m_g[16], m_v0[16], m_v1[16], m_d0[16], m_d1[16];
    logic [31:0] m_idx = '0;

    always #2.5 clk = ~clk;

    tlbp_top u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit ent_match(int i, logic [31:0] a, logic [7:0] as);
        logic [31:0] k;
        k = m_mask[i] | 32'h1FFF;
        return (m_g[i] || m_asid[i] == as) && ((a & ~k) == (m_vpn[i] & ~k));
    endfunction

    task automatic ref_lookup(input logic [31:0] va, input logic [7:0] as, input bit w,
                              output logic [1:0] code, output logic [31:0] pa);
        code = 2'd1;
        pa = '0;
        for (int i = 0; i < 16; i++) begin
            if (ent_match(i, va, as)) begin
                logic [31:0] k;
                bit odd, v, d;
                logic [31:0] pf;
                k   = m_mask[i] | 32'h1FFF;
                odd = |(va & k & ~(k >> 1));
                v   = odd ? m_v1[i] : m_v0[i];
                d   = odd ? m_d1[i] : m_d0[i];
                pf  = odd ? m_pf1[i] : m_pf0[i];
                if (!v) code = 2'd2;
                else if (w && !d) code = 2'd3;
                else begin
                    code = 2'd0;
                    pa = pf | (va & (k >> 1));
                end
                break;
            end
        end
    endtask

    task automatic do_write(input logic [3:0] ix, input logic [31:0] hi, input logic [31:0] l0,
                            input logic [31:0] l1, input logic [31:0] pm);
        @(negedge clk);
        reg_hi = hi; reg_lo0 = l0; reg_lo1 = l1; reg_pmask = pm;
        wr_index = ix; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        m_vpn[ix] = hi & ~32'h1FFF; m_asid[ix] = hi[7:0]; m_mask[ix] = pm;
        m_g[ix] = l0[0] & l1[0];
        m_v0[ix] = l0[1]; m_d0[ix] = l0[2]; m_pf0[ix] = l0 & 32'hFFFFF000;
        m_v1[ix] = l1[1]; m_d1[ix] = l1[2]; m_pf1[ix] = l1 & 32'hFFFFF000;
    endtask

    task automatic do_lookup(input logic [31:0] va, input logic [7:0] as, input bit w, input string req);
        logic [1:0]  ec;
        logic [31:0] ep;
        @(negedge clk);
        lk_va = va; lk_asid = as; lk_write = w;
        #1;
        ref_lookup(va, as, w, ec, ep);
        chk(lk_fault == ec, {req, " fault code"}, 32'(lk_fault), 32'(ec));
        chk(lk_hit == (ec == 2'd0), {req, " hit flag"}, 32'(lk_hit), 32'(ec == 2'd0));
        if (ec == 2'd0) chk(lk_pa == ep, {req, " physical address"}, lk_pa, ep);
    endtask

    task automatic check_readback(input string req);
        int i;
        logic [31:0] e0, e1;
        i = int'(m_idx[3:0]);
        e0 = m_pf0[i] | {29'd0, m_d0[i], m_v0[i], m_g[i]};
        e1 = m_pf1[i] | {29'd0, m_d1[i], m_v1[i], m_g[i]};
        chk(rd_hi == (m_vpn[i] | 32'(m_asid[i])), {req, " readback hi"}, rd_hi, m_vpn[i] | 32'(m_asid[i]));
        chk(rd_lo0 == e0, {req, " readback lo0"}, rd_lo0, e0);
        chk(rd_lo1 == e1, {req, " readback lo1"}, rd_lo1, e1);
        chk(rd_pmask == m_mask[i], {req, " readback mask"}, rd_pmask, m_mask[i]);
    endtask

    task automatic do_probe(input logic [31:0] key, input string req);
        bit found;
        found = 0;
        for (int i = 0; i < 16; i++) begin
            if (!found && ent_match(i, key, key[7:0])) begin
                found = 1;
                m_idx = 32'(i);
            end
        end
        if (!found) m_idx[31] = 1'b1;
        @(negedge clk);
        reg_hi = key; probe_go = 1'b1;
        @(negedge clk);
        probe_go = 1'b0;
        for (int k = 0; k < 40 && !probe_done; k++) @(negedge clk);
        chk(probe_done == 1'b1, {req, " probe completion"}, 32'(probe_done), 32'd1);
        chk(index_q == m_idx, {req, " index register"}, index_q, m_idx);
        check_readback(req);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL R12 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin
            m_vpn[i] = '0; m_mask[i] = '0; m_pf0[i] = '0; m_pf1[i] = '0; m_asid[i] = '0;
            m_g[i] = 0; m_v0[i] = 0; m_v1[i] = 0; m_d0[i] = 0; m_d1[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(index_q == 32'd0, "R11 index after reset", index_q, 32'd0);
        chk(probe_busy == 1'b0 && probe_done == 1'b0, "R11 probe idle", 32'(probe_busy), 32'd0);
        do_lookup(32'h0000_0123, 8'd5, 1'b0, "R11 R10 miss after reset");

        // R7 R6 R3 R5 basic entry
        do_write(4'd3, 32'h0040_2005, 32'h1234_5006, 32'h0ABC_D002, 32'h0);
        do_lookup(32'h0040_2123, 8'd5, 1'b0, "R3 R6 even read");
        do_lookup(32'h0040_2123, 8'd5, 1'b1, "R5 even write dirty");
        do_lookup(32'h0040_3456, 8'd5, 1'b0, "R3 R6 odd read ignores dirty R5");
        do_lookup(32'h0040_3456, 8'd5, 1'b1, "R5 odd write modified");
        do_lookup(32'h0040_2123, 8'd6, 1'b0, "R1 foreign asid R10");
        do_probe(32'h0040_2005, "R8 R7 probe entry 3");

        // R1 R7 global bit needs both low bits
        do_write(4'd7, 32'h1000_0011, 32'h5555_5007, 32'h6666_6007, 32'h0);
        do_write(4'd8, 32'h1100_0011, 32'h7777_7007, 32'h8888_8006, 32'h0);
        do_lookup(32'h1000_0abc, 8'd99, 1'b0, "R1 global any asid");
        do_lookup(32'h1100_0abc, 8'd99, 1'b0, "R7 global needs both halves");
        do_lookup(32'h1100_0abc, 8'h11, 1'b0, "R1 own asid");

        // R2 R3 R6 large page with stale bits under the mask
        do_write(4'd9, 32'h20A5_6003, 32'h3000_0006, 32'h4000_0002, 32'h0001_E000);
        do_lookup(32'h20A4_F123, 8'd3, 1'b0, "R2 R3 R6 large even");
        do_lookup(32'h20A5_0ABC, 8'd3, 1'b0, "R2 R3 R6 large odd");
        do_lookup(32'h20A6_0ABC, 8'd3, 1'b0, "R2 R10 beyond large pair");

        // R4 invalid half
        do_write(4'd10, 32'h3300_2004, 32'h9000_0006, 32'h9100_0004, 32'h0);
        do_lookup(32'h3300_3010, 8'd4, 1'b0, "R4 odd invalid");
        do_lookup(32'h3300_2010, 8'd4, 1'b1, "R4 even still valid");

        // R8 duplicates resolve to lowest index, R9 miss keeps field
        do_write(4'd14, 32'h4400_0002, 32'hA000_0006, 32'hA100_0006, 32'h0);
        do_write(4'd12, 32'h4400_0002, 32'hB000_0006, 32'hB100_0006, 32'h0);
        do_probe(32'h4400_0002, "R8 first of duplicates");
        do_lookup(32'h4400_0040, 8'd2, 1'b0, "R1 lowest index wins");
        do_probe(32'h7777_7001, "R9 probe no match");

        // R12 go while scanning ignored
        @(negedge clk);
        reg_hi = 32'h4400_0002; probe_go = 1'b1;
        @(negedge clk);
        chk(probe_busy == 1'b1, "R12 busy during scan", 32'(probe_busy), 32'd1);
        @(negedge clk);
        probe_go = 1'b0;
        for (int k = 0; k < 40 && !probe_done; k++) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(probe_busy == 1'b0 && probe_done == 1'b0, "R12 no restart from held go", 32'(probe_busy), 32'd0);
        m_idx = 32'd12;

        // random mix
        for (int it = 0; it < 600; it++) begin
            int op;
            logic [31:0] pm;
            op = int'($urandom % 4);
            case ($urandom % 3)
                0: pm = 32'h0;
                1: pm = 32'h6000;
                default: pm = 32'h1E000;
            endcase
            if (op == 0)
                do_write(4'($urandom % 16),
                         ((32'($urandom % 16)) << 13) | ($urandom & 32'h1F00) | 32'(1 + $urandom % 3),
                         ($urandom & 32'hFFFF_F000) | ($urandom & 32'h7),
                         ($urandom & 32'hFFFF_F000) | ($urandom & 32'h7), pm);
            else if (op == 3)
                do_probe(((32'($urandom % 16)) << 13) | 32'(1 + $urandom % 3), "R8 R9 R1 random probe");
            else
                do_lookup(((32'($urandom % 16)) << 13) | ($urandom & 32'h1FFF),
                          8'(1 + $urandom % 3), 1'($urandom % 2), "R1 R3 R4 R5 R6 random lookup");
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule